// File: doc/BRIEF.md
# Dual-Write Dual-Read Banked Memory

This block is a memory with two complete ports, A and B. In every clock cycle each port can store one word and fetch one word. Up to four accesses, on four independent addresses, are served in the same cycle. The storage is four plain RAM banks, each with one write port and one read port, plus a small array of flip-flops that holds one bit per address.

Each port writes its word into its own pair of banks. The per-address bit records which port stored that address most recently. Each port reads one bank written by A and one bank written by B, and the recorded bit chooses between the two words. Reads are synchronous and return data one clock after the address is presented. The value returned is the one stored before any write made in that same cycle.

Reset clears only the read output registers and the per-address owner bits. The stored words are left as they were.

Top module: `mem2w2r`

## Requirements
- R1: A port-A write (`a_we`=1) stores `a_wdata` at `a_waddr`. A later read of that address on either port returns it, as long as no newer write to that address has occurred.
- R2: A port-B write (`b_we`=1) stores `b_wdata` at `b_waddr`. A later read of that address on either port returns it, as long as no newer write to that address has occurred.
- R3: When both ports write the same address in different cycles, later reads of that address return the word from the most recent write, whichever port made it.
- R4: When both ports write the same address in the same cycle, port B's word is the one kept.
- R5: A read address sampled at a rising clock edge produces its word on the read data output after that edge. The output keeps its previous value until that edge.
- R6: A read of an address that is written in the same cycle returns the contents from before that write.
- R7: Both ports can write and read four different addresses in one cycle. Each access behaves as if it were alone. Two reads of the same address in the same cycle return equal words.
- R8: While `rst_n` is low, both read data outputs are 0 after a clock edge.
- R9: While a port's write enable is low, its write address and data have no effect on the stored contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for both ports |
| rst_n | input | 1 | Active-low asynchronous reset of the output registers and owner bits |
| a_we | input | 1 | Port A write enable |
| a_waddr | input | AW | Port A write address |
| a_wdata | input | DW | Port A write data |
| a_raddr | input | AW | Port A read address |
| a_rdata | output | DW | Port A read data, one cycle after `a_raddr` |
| b_we | input | 1 | Port B write enable |
| b_waddr | input | AW | Port B write address |
| b_wdata | input | DW | Port B write data |
| b_raddr | input | AW | Port B read address |
| b_rdata | output | DW | Port B read data, one cycle after `b_raddr` |

## Verification
A wrong owner bit does not corrupt any stored word. It makes a read pick the other port's bank copy, so the port returns a stale word from an older write. This shows up on the first read of that address after the bad write, one cycle after that read address is presented. The same-cycle collision sweep and the crossing-overwrite sweep target this directly. A bank that misses a write makes port A and port B disagree when both read the same address, and the bench makes such paired reads over every address.

// File: rtl/mem2w2r_pkg.sv
package mem2w2r_pkg;

  localparam int unsigned NUM_BANKS = 4;

  // owner bit values
  localparam logic OWNER_A = 1'b0;
  localparam logic OWNER_B = 1'b1;

  // bank k is written by port k[1] (0 = A, 1 = B)
  function automatic logic bank_writer(input int unsigned k);
    return k[1];
  endfunction

  // bank k is read by port k[0] (0 = A, 1 = B)
  function automatic logic bank_reader(input int unsigned k);
    return k[0];
  endfunction

  // next owner of one address: B beats A on a collision
  function automatic logic next_owner(input logic cur, input logic a_hit, input logic b_hit);
    logic r;
    r = cur;
    if (a_hit) r = OWNER_A;
    if (b_hit) r = OWNER_B;
    return r;
  endfunction

endpackage

// File: rtl/m2_bank.sv
module m2_bank #(
  parameter int unsigned AW = 4,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata_q
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] store [DEPTH];

  // storage is never cleared
  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  // registered read; sees contents before this cycle's write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= store[raddr];
  end
endmodule

// File: rtl/m2_owner.sv
module m2_owner #(
  parameter int unsigned AW = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               a_we,
  input  logic [AW-1:0]      a_waddr,
  input  logic               b_we,
  input  logic [AW-1:0]      b_waddr,
  input  logic [AW-1:0]      a_raddr,
  input  logic [AW-1:0]      b_raddr,
  output logic               a_own_q,
  output logic               b_own_q,
  output logic [(1<<AW)-1:0] own_vec
);
  import mem2w2r_pkg::*;
  localparam int unsigned DEPTH = 1 << AW;

  logic [DEPTH-1:0] own_d;

  for (genvar i = 0; i < DEPTH; i++) begin : g_bit
    logic a_hit, b_hit;
    assign a_hit    = a_we && (a_waddr == AW'(i));
    assign b_hit    = b_we && (b_waddr == AW'(i));
    assign own_d[i] = next_owner(own_vec[i], a_hit, b_hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) own_vec <= '0;
    else        own_vec <= own_d;
  end

  // owner bits registered alongside the bank read registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_own_q <= OWNER_A;
      b_own_q <= OWNER_A;
    end else begin
      a_own_q <= own_vec[a_raddr];
      b_own_q <= own_vec[b_raddr];
    end
  end
endmodule

// File: rtl/m2_pick.sv
module m2_pick #(
  parameter int unsigned DW = 8
) (
  input  logic          own,
  input  logic [DW-1:0] from_a,
  input  logic [DW-1:0] from_b,
  output logic [DW-1:0] dout
);
  import mem2w2r_pkg::*;
  always_comb begin
    if (own == OWNER_B) dout = from_b;
    else                dout = from_a;
  end
endmodule

// File: rtl/mem2w2r.sv
module mem2w2r #(
  parameter int unsigned AW = 4,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_we,
  input  logic [AW-1:0] a_waddr,
  input  logic [DW-1:0] a_wdata,
  input  logic [AW-1:0] a_raddr,
  output logic [DW-1:0] a_rdata,
  input  logic          b_we,
  input  logic [AW-1:0] b_waddr,
  input  logic [DW-1:0] b_wdata,
  input  logic [AW-1:0] b_raddr,
  output logic [DW-1:0] b_rdata
);
  import mem2w2r_pkg::*;
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0]    bank_q [NUM_BANKS];
  logic [DEPTH-1:0] sel_vec;
  logic             a_own_q, b_own_q;

  for (genvar k = 0; k < NUM_BANKS; k++) begin : g_bank
    logic          wr_en;
    logic [AW-1:0] wr_addr, rd_addr;
    logic [DW-1:0] wr_data;

    if (bank_writer(k) == OWNER_B) begin : g_wb
      assign wr_en   = b_we;
      assign wr_addr = b_waddr;
      assign wr_data = b_wdata;
    end else begin : g_wa
      assign wr_en   = a_we;
      assign wr_addr = a_waddr;
      assign wr_data = a_wdata;
    end

    if (bank_reader(k)) begin : g_rb
      assign rd_addr = b_raddr;
    end else begin : g_ra
      assign rd_addr = a_raddr;
    end

    m2_bank #(.AW(AW), .DW(DW)) u_bank (
      .clk(clk), .rst_n(rst_n), .we(wr_en), .waddr(wr_addr),
      .wdata(wr_data), .raddr(rd_addr), .rdata_q(bank_q[k])
    );
  end

  m2_owner #(.AW(AW)) u_owner (
    .clk(clk), .rst_n(rst_n),
    .a_we(a_we), .a_waddr(a_waddr), .b_we(b_we), .b_waddr(b_waddr),
    .a_raddr(a_raddr), .b_raddr(b_raddr),
    .a_own_q(a_own_q), .b_own_q(b_own_q), .own_vec(sel_vec)
  );

  // port A reads banks 0 and 2, port B reads banks 1 and 3
  m2_pick #(.DW(DW)) u_pick_a (.own(a_own_q), .from_a(bank_q[0]), .from_b(bank_q[2]), .dout(a_rdata));
  m2_pick #(.DW(DW)) u_pick_b (.own(b_own_q), .from_a(bank_q[1]), .from_b(bank_q[3]), .dout(b_rdata));
endmodule

// File: rtl/m2_checker.sv
module m2_checker #(
  parameter int unsigned AW = 4,
  parameter int unsigned DW = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               a_we,
  input logic [AW-1:0]      a_waddr,
  input logic [AW-1:0]      a_raddr,
  input logic [DW-1:0]      a_rdata,
  input logic               b_we,
  input logic [AW-1:0]      b_waddr,
  input logic [AW-1:0]      b_raddr,
  input logic [DW-1:0]      b_rdata,
  input logic [(1<<AW)-1:0] sel_vec
);
  // R1: a lone port-A write makes A the owner
  assert_a_owner_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (a_we && !(b_we && b_waddr == a_waddr)) |=> (sel_vec[$past(a_waddr)] == 1'b0));

  // R2: a port-B write makes B the owner
  assert_b_owner_R2: assert property (@(posedge clk) disable iff (!rst_n)
    b_we |=> (sel_vec[$past(b_waddr)] == 1'b1));

  // R4: a same-address collision leaves B as owner
  assert_collision_b_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (a_we && b_we && a_waddr == b_waddr) |=> (sel_vec[$past(a_waddr)] == 1'b1));

  // R9: no write enable, no owner change
  assert_idle_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!a_we && !b_we) |=> $stable(sel_vec));

  // R7: both ports reading one address see the same word
  assert_same_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (a_raddr == b_raddr) |=> (a_rdata == b_rdata));
endmodule

bind mem2w2r m2_checker #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .a_we(a_we), .a_waddr(a_waddr), .a_raddr(a_raddr), .a_rdata(a_rdata),
  .b_we(b_we), .b_waddr(b_waddr), .b_raddr(b_raddr), .b_rdata(b_rdata),
  .sel_vec(sel_vec)
);

// File: tb/sim_mem2w2r.sv
module sim_mem2w2r;
  localparam int unsigned AW = 4;
  localparam int unsigned DW = 8;
  localparam int unsigned DEPTH = 1 << AW;
  localparam time CLK_PERIOD = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          a_we = 1'b0, b_we = 1'b0;
  logic [AW-1:0] a_waddr = '0, a_raddr = '0, b_waddr = '0, b_raddr = '0;
  logic [DW-1:0] a_wdata = '0, b_wdata = '0;
  logic [DW-1:0] a_rdata, b_rdata;

  int checks = 0;
  int fails = 0;

  logic [DW-1:0] model [DEPTH];
  bit            known [DEPTH];
  logic [DW-1:0] prev_a, prev_b;
  bit            prev_a_ok = 1'b0, prev_b_ok = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mem2w2r #(.AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .a_we(a_we), .a_waddr(a_waddr), .a_wdata(a_wdata), .a_raddr(a_raddr), .a_rdata(a_rdata),
    .b_we(b_we), .b_waddr(b_waddr), .b_wdata(b_wdata), .b_raddr(b_raddr), .b_rdata(b_rdata)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
    end
  endtask

  // one cycle: drive at falling edge, check hold, then check result after rising edge
  task automatic step(input string req,
                      input bit aw, input int awa, input int awd, input int ara,
                      input bit bw, input int bwa, input int bwd, input int bra);
    logic [DW-1:0] ea, eb;
    bit ea_ok, eb_ok;
    @(negedge clk);
    a_we = aw; a_waddr = AW'(awa); a_wdata = DW'(awd); a_raddr = AW'(ara);
    b_we = bw; b_waddr = AW'(bwa); b_wdata = DW'(bwd); b_raddr = AW'(bra);
    #1;
    if (prev_a_ok) check("R5 hold A", a_rdata, prev_a);
    if (prev_b_ok) check("R5 hold B", b_rdata, prev_b);
    ea = model[ara]; ea_ok = known[ara];
    eb = model[bra]; eb_ok = known[bra];
    if (aw) begin model[awa] = DW'(awd); known[awa] = 1'b1; end
    if (bw) begin model[bwa] = DW'(bwd); known[bwa] = 1'b1; end
    @(posedge clk); #1;
    if (ea_ok) check({req, " A"}, a_rdata, ea);
    if (eb_ok) check({req, " B"}, b_rdata, eb);
    prev_a = ea; prev_a_ok = ea_ok;
    prev_b = eb; prev_b_ok = eb_ok;
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) known[i] = 1'b0;
    // R8: outputs cleared while reset is low
    repeat (3) @(posedge clk);
    #1;
    check("R8 reset A", a_rdata, '0);
    check("R8 reset B", b_rdata, '0);
    @(negedge clk); rst_n = 1'b1;

    // R1 / R2: A fills even addresses, B fills odd ones
    for (int i = 0; i < DEPTH; i += 2)
      step("R1R2 fill", 1'b1, i, 8'h10 + i, 0, 1'b1, i + 1, 8'h80 + i, 0);
    for (int i = 0; i < DEPTH; i++)
      step("R1R2 readback", 1'b0, 0, 0, i, 1'b0, 0, 0, DEPTH - 1 - i);

    // R3: each port overwrites what the other stored
    for (int i = 0; i < DEPTH; i += 2)
      step("R3 cross", 1'b1, i + 1, 8'h40 + i, i, 1'b1, i, 8'hC0 + i, i + 1);
    for (int i = 0; i < DEPTH; i++)
      step("R3 readback", 1'b0, 0, 0, i, 1'b0, 0, 0, i);

    // R4: same-address collision on every address
    for (int i = 0; i < DEPTH; i++)
      step("R4 collide", 1'b1, i, 8'h20 + i, (i + 3) % DEPTH, 1'b1, i, 8'hE0 + i, (i + 5) % DEPTH);
    for (int i = 0; i < DEPTH; i++)
      step("R4 readback", 1'b0, 0, 0, i, 1'b0, 0, 0, i);

    // R6: read the address being written in the same cycle
    for (int i = 0; i < DEPTH; i++)
      step("R6 rbw", 1'b1, i, 8'h55 ^ i, i, 1'b1, (i + 1) % DEPTH, 8'hAA ^ i, (i + 1) % DEPTH);

    // R9: enables low, address and data wiggle
    for (int i = 0; i < DEPTH; i++)
      step("R9 idle", 1'b0, i, 8'hFF - i, (i + 7) % DEPTH, 1'b0, DEPTH - 1 - i, 8'h0F + i, i);
    for (int i = 0; i < DEPTH; i++)
      step("R9 readback", 1'b0, 0, 0, i, 1'b0, 0, 0, i);

    // R7: concurrent pseudo-random traffic on four addresses
    for (int n = 0; n < 3000; n++) begin
      int r;
      r = $urandom;
      step("R7 random", r[0], $urandom % DEPTH, $urandom % 256, $urandom % DEPTH,
                        r[1], $urandom % DEPTH, $urandom % 256, $urandom % DEPTH);
    end
    for (int i = 0; i < DEPTH; i++)
      step("R7 final", 1'b0, 0, 0, i, 1'b0, 0, 0, i);

    finish_run();
  end
endmodule